// File: doc/BRIEF.md
# Framed Reply Message Encoder

This block assembles outgoing reply and status messages for a byte-wide serial transmitter. A control agent first pushes payload bytes into a small internal FIFO. It then issues a start command that carries the message kind, a start address and a payload length. The encoder emits the complete frame one byte per accepted handshake. The frame is a start marker, a type code, the address, the length, the payload bytes taken from the FIFO, a CRC-8 and an end marker.

The CRC is built up as the bytes go out, so no second pass over the payload is needed. A start command is rejected with a one-cycle error pulse, and no frame is sent, when the requested length exceeds the number of bytes held in the FIFO. Payload bytes that a frame does not consume stay in the FIFO for the next frame.

Top module: `frame_encoder`

## Requirements
- R1: After reset `busy`, `out_valid` and `len_err` are low and the payload FIFO is empty.
- R2: A frame is emitted in this order: start marker 0x00, type code, address, length, the `len` payload bytes in the order they were loaded, the CRC byte, end marker 0x15.
- R3: The type code is 0x07 when `kind` is 0 (reply) and 0x18 when `kind` is 1 (status).
- R4: The CRC byte is the CRC-8 with generator x^8+x^7+x^6+x^4+x^2+1 (0xD5), register seeded with 0x00, with each byte fed most significant bit first and no final inversion. It covers the type, address, length and payload bytes only.
- R5: A byte is transferred only in a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R6: `busy` and `out_valid` rise in the cycle after an accepted start. They fall in the cycle after the end marker is transferred.
- R7: A start command that arrives while `busy` is high has no effect on the frame in progress.
- R8: If `len` exceeds the number of bytes held in the FIFO, `len_err` pulses high for exactly the cycle after the start. No frame is emitted and the FIFO contents are kept.
- R9: The FIFO holds 16 bytes. A load while it is full is dropped. Bytes left over after a frame are sent first by the next frame.
- R10: With `len` equal to 0, the CRC byte directly follows the length byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Push `load_data` into the payload FIFO |
| load_data | input | 8 | Payload byte |
| start | input | 1 | Start command, sampled when idle |
| kind | input | 1 | 0 = reply, 1 = status |
| addr | input | 8 | Start address field |
| len | input | 8 | Payload length field |
| out_valid | output | 1 | Frame byte available |
| out_data | output | 8 | Frame byte |
| out_ready | input | 1 | Transmitter accepts the byte |
| busy | output | 1 | Frame in progress |
| len_err | output | 1 | Start rejected: length exceeds FIFO contents |

## Verification
The bench compares whole frames against a reference frame and CRC that it builds itself. It covers several cases: a reply with a short payload, a status frame with no payload, a full 16-byte frame under irregular backpressure, and two frames that share one FIFO load. With no payload, a missing or extra data state shows up. Backpressure finds bytes that advance or change without a handshake. The shared load finds pointer errors and leftover bytes that were discarded. An overfilled FIFO and a length larger than the stored count check the depth limit and the rejection path. A start pulse in the middle of a frame shows whether a running frame can be disturbed.

// File: rtl/frame_encoder.sv
module frame_encoder #(
  parameter int         DEPTH  = 16,
  parameter logic [7:0] SOF    = 8'h00,
  parameter logic [7:0] EOF    = 8'h15,
  parameter logic [7:0] T_REPLY  = 8'h07,
  parameter logic [7:0] T_STATUS = 8'h18,
  parameter logic [7:0] POLY   = 8'hD5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_valid,
  input  logic [7:0] load_data,
  input  logic       start,
  input  logic       kind,
  input  logic [7:0] addr,
  input  logic [7:0] len,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       busy,
  output logic       len_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_SOF, S_TYPE, S_ADDR, S_LEN, S_DATA, S_CRC, S_EOF} st_t;
  st_t st;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [7:0]    f_type, f_addr, f_len, rem, crc;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  wire accept = out_valid && out_ready;
  wire push   = load_valid && (int'(cnt) < DEPTH);
  wire pop    = (st == S_DATA) && out_ready;
  wire go     = start && (st == S_IDLE);
  wire short  = int'(len) > int'(cnt);

  assign out_valid = (st != S_IDLE);
  assign busy      = out_valid;

  always_comb begin
    case (st)
      S_SOF:   out_data = SOF;
      S_TYPE:  out_data = f_type;
      S_ADDR:  out_data = f_addr;
      S_LEN:   out_data = f_len;
      S_DATA:  out_data = mem[rp];
      S_CRC:   out_data = crc;
      S_EOF:   out_data = EOF;
      default: out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= load_data;
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      len_err <= 1'b0;
      f_type  <= '0;
      f_addr  <= '0;
      f_len   <= '0;
      rem     <= '0;
      crc     <= '0;
    end else begin
      len_err <= go && short;
      if (go && !short) begin
        st     <= S_SOF;
        f_type <= kind ? T_STATUS : T_REPLY;
        f_addr <= addr;
        f_len  <= len;
        rem    <= len;
        crc    <= '0;
      end else if (accept) begin
        case (st)
          S_SOF:  st <= S_TYPE;
          S_TYPE: begin crc <= crc_step(crc, out_data); st <= S_ADDR; end
          S_ADDR: begin crc <= crc_step(crc, out_data); st <= S_LEN;  end
          S_LEN: begin
            crc <= crc_step(crc, out_data);
            st  <= (rem == 8'd0) ? S_CRC : S_DATA;
          end
          S_DATA: begin
            crc <= crc_step(crc, out_data);
            rem <= rem - 1'b1;
            if (rem == 8'd1) st <= S_CRC;
          end
          S_CRC:   st <= S_EOF;
          S_EOF:   st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_encoder_chk.sv
module frame_encoder_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          out_ready,
  input logic          busy,
  input logic          len_err,
  input logic [CW-1:0] cnt
);
  // R5
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R2
  frame_opens_with_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> out_data == 8'h00);
  // R6
  frame_closes_on_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_data) == 8'h15 && $past(out_ready));
  // R8
  reject_emits_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !busy && !out_valid);
  // R8
  reject_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err);
  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
endmodule

bind frame_encoder frame_encoder_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .busy(busy),
  .len_err(len_err), .cnt(cnt)
);

// File: tb/frame_encoder_bench.sv
module frame_encoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic load_valid = 0, start = 0, kind = 0, out_ready = 0;
  logic [7:0] load_data = 0, addr = 0, len = 0;
  logic out_valid, busy, len_err;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model_q[$];
  logic [7:0] exp_f[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_encoder u_frame_encoder (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .start(start), .kind(kind), .addr(addr), .len(len),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(busy), .len_err(len_err)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'hD5;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_valid = 1; load_data = base + 8'(i);
      if (model_q.size() < 16) model_q.push_back(base + 8'(i));
    end
    @(negedge clk);
    load_valid = 0;
  endtask

  task automatic build(input logic k, input logic [7:0] a, input logic [7:0] l);
    logic [7:0] c = 0;
    logic [7:0] t = k ? 8'h18 : 8'h07;
    exp_f.delete();
    exp_f.push_back(8'h00);
    exp_f.push_back(t); c = ref_crc(c, t);
    exp_f.push_back(a); c = ref_crc(c, a);
    exp_f.push_back(l); c = ref_crc(c, l);
    for (int i = 0; i < int'(l); i++) begin
      logic [7:0] d = model_q.pop_front();
      exp_f.push_back(d); c = ref_crc(c, d);
    end
    exp_f.push_back(c);
    exp_f.push_back(8'h15);
  endtask

  // stall: 0 = always ready, otherwise ready low on cycles where (cyc % stall)==0
  task automatic run_frame(input string req, input logic k, input logic [7:0] a,
                           input logic [7:0] l, input int stall, input bit poke);
    int idx = 0, cyc = 0;
    logic [7:0] held = 0;
    bit was_stalled = 0;
    build(k, a, l);
    @(negedge clk);
    kind = k; addr = a; len = l; start = 1;
    @(negedge clk);
    start = 0;
    check({req, " R6 busy after start"}, busy, 1);
    while (idx < exp_f.size() && cyc < 1000) begin
      if (!out_valid) begin
        check({req, " R6 valid during frame"}, out_valid, 1);
        break;
      end
      if (was_stalled) check({req, " R5 hold"}, out_data, held);
      if (poke && idx == 4) begin start = 1; kind = ~k; len = 0; end
      else start = 0;
      out_ready = (stall == 0) || (cyc % stall != 0);
      if (out_ready) begin
        check($sformatf("%s R2/R3/R4 byte %0d", req, idx), out_data, exp_f[idx]);
        idx++;
        was_stalled = 0;
      end else begin
        was_stalled = 1; held = out_data;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 0; start = 0;
    check({req, " R6 busy low after end"}, busy, 0);
    check({req, " R6 valid low after end"}, out_valid, 0);
    repeat (2) @(negedge clk);
    check({req, " R7 no extra frame"}, busy, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 len_err", len_err, 0);
  endtask

  task automatic t_reject(input logic [7:0] l);
    @(negedge clk);
    kind = 0; addr = 8'h33; len = l; start = 1;
    @(negedge clk);
    start = 0;
    check("R8 len_err pulse", len_err, 1);
    check("R8 no busy", busy, 0);
    check("R8 no valid", out_valid, 0);
    @(negedge clk);
    check("R8 pulse ends", len_err, 0);
    check("R8 still idle", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reject(8'd1);                         // R1 FIFO empty
    load(3, 8'hA0);
    run_frame("reply3", 0, 8'h12, 8'd3, 0, 0);
    run_frame("status0 R10", 1, 8'hFE, 8'd0, 0, 0);
    load(17, 8'h40);                        // R9 seventeenth load dropped
    run_frame("full16 R9", 0, 8'h80, 8'd16, 3, 0);
    t_reject(8'd1);                         // R9 FIFO empty after 16
    load(4, 8'hC0);
    t_reject(8'd5);                         // R8 keeps 4 bytes
    run_frame("split1 R9", 1, 8'h01, 8'd2, 2, 1);  // R7 poke mid-frame
    run_frame("split2 R9", 0, 8'h02, 8'd2, 4, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule